// File: doc/BRIEF.md
# Exception Vector Fetch Unit

The unit accepts one exception request at a time and resolves it to an 8-bit vector number. The number can come from a fixed table of internal causes, from a trap number, or from the interrupt-acknowledge response. That response can be a byte supplied by a peripheral, an autovector chosen by interrupt level, or the spurious vector when the acknowledge ends in a bus error. The unit scales the vector number by four and adds an optional, word-aligned vector base register. It truncates the result to the bus width and then reads the handler address from memory over a word-wide request/acknowledge port.

A normal exception reads two consecutive words from supervisor data space, high half first, and returns them as the new 32-bit program counter. A reset request reads four words from supervisor program space, starting at absolute address zero. The first two words become the initial stack pointer and the last two become the new program counter. A bus error on any of these vector reads puts the unit into a sticky fault state. Only a reset of the unit clears that state.

Top module: `excVecFetch`

## Requirements
- R1: The `cause` code selects a fixed vector number as follows: 0 reset→0, 1 bus error→2, 2 address error→3, 3 illegal→4, 4 zero divide→5, 5 bounds check→6, 6 overflow trap→7, 7 privilege→8, 8 trace→9, 9 line-A opcode→10, 10 line-F opcode→11, 11 uninitialized interrupt→15. Codes 14 and 15 select vector 4. The chosen number appears on `vecNum` once the request is accepted.
- R2: Cause code 12 (software trap) selects vector 32 + `trapNum`, for `trapNum` 0 to 15.
- R3: Cause code 13 (interrupt) takes its vector from `ackKind`. Kind 0 uses `ackVector` (data lines 7..0). Kind 1 uses 24 + `irqLevel`. Kinds 2 and 3 (acknowledge bus error) use the spurious vector 24.
- R4: The first read of a non-reset request goes to word address (base + 2·vector) modulo 2^(ADDR_W-1), which equals byte address base + 4·vector truncated to ADDR_W bits. `memAddr` carries byte-address bits ADDR_W-1..1.
- R5: The base register is loaded from `baseWrData` (word units) when `baseWe` is high. It clears to zero when `rstN` is low. A reset request ignores it and always starts at address zero.
- R6: A non-reset request makes exactly two reads at consecutive word addresses with `memSpace` = 0 (supervisor data). The first word becomes `newPc[31:16]` and the second becomes `newPc[15:0]`.
- R7: A reset request makes exactly four reads at word addresses 0 to 3 with `memSpace` = 1 (supervisor program). The words form `initSp` (first two) and `newPc` (last two), high half first.
- R8: While `memReq` is high and `memAck` is low, `memReq`, `memAddr` and `memSpace` stay unchanged. Any number of stall cycles gives the same result.
- R9: `done` is high for exactly one cycle, in the cycle after the last word is acknowledged. `busy` is low in that cycle. After reset the unit is idle with `done`, `fault` and `memReq` low.
- R10: A `start` pulse while `busy` is high is ignored. The running request finishes with its own vector and word count.
- R11: If `memBusErr` is high with `memAck` on any vector read, `fault` rises and stays high. `done` never pulses, no further reads are issued, and `busy` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| cause | input | 4 | Exception cause code |
| trapNum | input | 4 | Software trap number |
| irqLevel | input | 3 | Interrupt level for autovectoring |
| ackKind | input | 2 | Interrupt-acknowledge outcome |
| ackVector | input | 8 | Peripheral vector byte (data lines 7..0) |
| baseWe | input | 1 | Vector base register write enable |
| baseWrData | input | ADDR_W-1 | New base value, word units |
| memReq | output | 1 | Read request |
| memAddr | output | ADDR_W-1 | Word address (byte-address bits ADDR_W-1..1) |
| memSpace | output | 1 | 0 supervisor data, 1 supervisor program |
| memAck | input | 1 | Read acknowledge |
| memData | input | 16 | Read data word |
| memBusErr | input | 1 | Bus error, qualified by memAck |
| busy | output | 1 | Request in progress or faulted |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Sticky vector-read bus error |
| vecNum | output | 8 | Vector number of the accepted request |
| newPc | output | 32 | Fetched program counter |
| initSp | output | 32 | Fetched initial stack pointer (reset only) |

## Verification
A wrong vector number or a corrupted base shows on the first read address, one cycle after `start`, and on `vecNum` in the same cycle. A broken word counter shows as a wrong number of acknowledged reads or a misplaced `done`, within a few cycles of the last acknowledge. A wrong slot index or a wrong space flag shows as swapped halves in `newPc`/`initSp`, or as the wrong `memSpace`, and is visible at `done`. A fault state that leaks shows as a `done` pulse or a fresh `memReq` after the erroring acknowledge.

// File: rtl/excVecPkg.sv
package excVecPkg;

  localparam logic [3:0] CAUSE_RESET   = 4'd0;
  localparam logic [3:0] CAUSE_BUSERR  = 4'd1;
  localparam logic [3:0] CAUSE_ADDRERR = 4'd2;
  localparam logic [3:0] CAUSE_ILLEGAL = 4'd3;
  localparam logic [3:0] CAUSE_ZERODIV = 4'd4;
  localparam logic [3:0] CAUSE_BOUNDS  = 4'd5;
  localparam logic [3:0] CAUSE_OVFTRAP = 4'd6;
  localparam logic [3:0] CAUSE_PRIV    = 4'd7;
  localparam logic [3:0] CAUSE_TRACE   = 4'd8;
  localparam logic [3:0] CAUSE_LINEA   = 4'd9;
  localparam logic [3:0] CAUSE_LINEF   = 4'd10;
  localparam logic [3:0] CAUSE_UNINIT  = 4'd11;
  localparam logic [3:0] CAUSE_TRAP    = 4'd12;
  localparam logic [3:0] CAUSE_IRQ     = 4'd13;

  localparam logic [1:0] ACK_VECTOR = 2'd0;
  localparam logic [1:0] ACK_AUTO   = 2'd1;

  localparam logic [7:0] VEC_SPURIOUS  = 8'd24;
  localparam logic [7:0] VEC_AUTO_BASE = 8'd24;
  localparam logic [7:0] VEC_TRAP_BASE = 8'd32;
  localparam logic [7:0] VEC_ILLEGAL   = 8'd4;

  localparam logic SPACE_DATA = 1'b0;
  localparam logic SPACE_PROG = 1'b1;

  localparam int RESET_WORDS  = 4;
  localparam int NORMAL_WORDS = 2;

  typedef struct packed {
    logic       load;     // request accepted this cycle
    logic       take;     // a vector word accepted this cycle
    logic [1:0] wordIdx;  // index of the word being read
  } ctlStrobe_t;

  function automatic logic [7:0] pickVector(
    input logic [3:0] c,
    input logic [3:0] tn,
    input logic [2:0] lv,
    input logic [1:0] ak,
    input logic [7:0] av
  );
    logic [7:0] v;
    case (c)
      CAUSE_RESET:   v = 8'd0;
      CAUSE_BUSERR:  v = 8'd2;
      CAUSE_ADDRERR: v = 8'd3;
      CAUSE_ILLEGAL: v = 8'd4;
      CAUSE_ZERODIV: v = 8'd5;
      CAUSE_BOUNDS:  v = 8'd6;
      CAUSE_OVFTRAP: v = 8'd7;
      CAUSE_PRIV:    v = 8'd8;
      CAUSE_TRACE:   v = 8'd9;
      CAUSE_LINEA:   v = 8'd10;
      CAUSE_LINEF:   v = 8'd11;
      CAUSE_UNINIT:  v = 8'd15;
      CAUSE_TRAP:    v = VEC_TRAP_BASE + {4'd0, tn};
      CAUSE_IRQ: begin
        if (ak == ACK_VECTOR)    v = av;
        else if (ak == ACK_AUTO) v = VEC_AUTO_BASE + {5'd0, lv};
        else                     v = VEC_SPURIOUS;
      end
      default:       v = VEC_ILLEGAL;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/excVecCtrl.sv
module excVecCtrl
  import excVecPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isResetReq,
  input  logic       memAck,
  input  logic       memBusErr,
  output ctlStrobe_t stb,
  output logic       memReq,
  output logic       busy,
  output logic       done,
  output logic       fault
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FAULT} state_e;

  localparam logic [1:0] LAST_RESET  = 2'(RESET_WORDS - 1);
  localparam logic [1:0] LAST_NORMAL = 2'(NORMAL_WORDS - 1);

  state_e     state;
  logic [1:0] wordIdx;
  logic [1:0] lastIdx;
  logic       doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      lastIdx <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_FETCH;
            wordIdx <= '0;
            lastIdx <= isResetReq ? LAST_RESET : LAST_NORMAL;
          end
        end
        ST_FETCH: begin
          if (memAck) begin
            if (memBusErr) begin
              state <= ST_FAULT;
            end else if (wordIdx == lastIdx) begin
              state   <= ST_IDLE;
              doneReg <= 1'b1;
            end else begin
              wordIdx <= wordIdx + 2'd1;
            end
          end
        end
        default: state <= ST_FAULT;
      endcase
    end
  end

  always_comb begin
    stb.load    = (state == ST_IDLE) && start;
    stb.take    = (state == ST_FETCH) && memAck && !memBusErr;
    stb.wordIdx = wordIdx;
  end

  assign memReq = (state == ST_FETCH);
  assign busy   = (state != ST_IDLE);
  assign fault  = (state == ST_FAULT);
  assign done   = doneReg;

endmodule

// File: rtl/excVecPath.sv
module excVecPath
  import excVecPkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter bit USE_BASE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [3:0]        cause,
  input  logic [3:0]        trapNum,
  input  logic [2:0]        irqLevel,
  input  logic [1:0]        ackKind,
  input  logic [7:0]        ackVector,
  input  logic              baseWe,
  input  logic [ADDR_W-1:1] baseWrData,
  input  logic [15:0]       memData,
  output logic              isResetReq,
  output logic [7:0]        vecNum,
  output logic [ADDR_W-1:1] memAddr,
  output logic              memSpace,
  output logic [31:0]       newPc,
  output logic [31:0]       initSp
);

  localparam int WA_W  = ADDR_W - 1;
  localparam int SLOTS = RESET_WORDS;

  logic [WA_W-1:0] baseWord;

  generate
    if (USE_BASE) begin : g_base
      logic [WA_W-1:0] baseReg;
      always_ff @(posedge clk) begin
        if (!rstN)       baseReg <= '0;
        else if (baseWe) baseReg <= baseWrData;
      end
      assign baseWord = baseReg;
    end else begin : g_noBase
      assign baseWord = '0;
    end
  endgenerate

  logic [7:0]      vecSel;
  logic [WA_W-1:0] offsetWord;
  logic [WA_W-1:0] startWord;

  assign vecSel     = pickVector(cause, trapNum, irqLevel, ackKind, ackVector);
  assign isResetReq = (cause == CAUSE_RESET);
  assign offsetWord = WA_W'({vecSel, 1'b0});
  assign startWord  = isResetReq ? '0 : baseWord + offsetWord;

  logic [7:0]      vecReg;
  logic [WA_W-1:0] addrReg;
  logic            spaceReg;
  logic [15:0]     wordBuf [SLOTS];
  logic [1:0]      slot;

  assign slot = (spaceReg == SPACE_PROG) ? stb.wordIdx : stb.wordIdx + 2'd2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg   <= '0;
      addrReg  <= '0;
      spaceReg <= SPACE_DATA;
      for (int i = 0; i < SLOTS; i++) wordBuf[i] <= '0;
    end else begin
      if (stb.load) begin
        vecReg   <= vecSel;
        addrReg  <= startWord;
        spaceReg <= isResetReq ? SPACE_PROG : SPACE_DATA;
      end
      if (stb.take) begin
        addrReg       <= addrReg + 1'b1;
        wordBuf[slot] <= memData;
      end
    end
  end

  assign vecNum   = vecReg;
  assign memAddr  = addrReg;
  assign memSpace = spaceReg;
  assign initSp   = {wordBuf[0], wordBuf[1]};
  assign newPc    = {wordBuf[2], wordBuf[3]};

endmodule

// File: rtl/excVecFetch.sv
module excVecFetch
  import excVecPkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter bit USE_BASE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        cause,
  input  logic [3:0]        trapNum,
  input  logic [2:0]        irqLevel,
  input  logic [1:0]        ackKind,
  input  logic [7:0]        ackVector,
  input  logic              baseWe,
  input  logic [ADDR_W-1:1] baseWrData,
  output logic              memReq,
  output logic [ADDR_W-1:1] memAddr,
  output logic              memSpace,
  input  logic              memAck,
  input  logic [15:0]       memData,
  input  logic              memBusErr,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [7:0]        vecNum,
  output logic [31:0]       newPc,
  output logic [31:0]       initSp
);

  ctlStrobe_t stb;
  logic       isResetReq;

  excVecCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .isResetReq (isResetReq),
    .memAck     (memAck),
    .memBusErr  (memBusErr),
    .stb        (stb),
    .memReq     (memReq),
    .busy       (busy),
    .done       (done),
    .fault      (fault)
  );

  excVecPath #(
    .ADDR_W   (ADDR_W),
    .USE_BASE (USE_BASE)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cause      (cause),
    .trapNum    (trapNum),
    .irqLevel   (irqLevel),
    .ackKind    (ackKind),
    .ackVector  (ackVector),
    .baseWe     (baseWe),
    .baseWrData (baseWrData),
    .memData    (memData),
    .isResetReq (isResetReq),
    .vecNum     (vecNum),
    .memAddr    (memAddr),
    .memSpace   (memSpace),
    .newPc      (newPc),
    .initSp     (initSp)
  );

endmodule

// File: rtl/excVecChk.sv
module excVecChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              memReq,
  input logic              memAck,
  input logic              memBusErr,
  input logic [ADDR_W-1:1] memAddr,
  input logic              memSpace
);

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memSpace));

  a_r6_next_word_addr: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && !memBusErr |=> !memReq || (memAddr == $past(memAddr) + 1'b1));

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !memReq);

  a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault && !done && !memReq && busy);

  a_r11_err_to_fault: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && memBusErr |=> fault);

  a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

endmodule

bind excVecFetch excVecChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .memReq    (memReq),
  .memAck    (memAck),
  .memBusErr (memBusErr),
  .memAddr   (memAddr),
  .memSpace  (memSpace)
);

// File: tb/excVecFetch_tb.sv
module excVecFetch_tb;

  localparam int CLK_P = 10;
  localparam int AW    = 24;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [3:0]    cause;
  logic [3:0]    trapNum;
  logic [2:0]    irqLevel;
  logic [1:0]    ackKind;
  logic [7:0]    ackVector;
  logic          baseWe;
  logic [AW-1:1] baseWrData;
  logic          memReq;
  logic [AW-1:1] memAddr;
  logic          memSpace;
  logic          memAck;
  logic [15:0]   memData;
  logic          memBusErr;
  logic          busy, done, fault;
  logic [7:0]    vecNum;
  logic [31:0]   newPc, initSp;

  always #(CLK_P/2) clk = ~clk;

  excVecFetch #(.ADDR_W(AW), .USE_BASE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cause(cause), .trapNum(trapNum),
    .irqLevel(irqLevel), .ackKind(ackKind), .ackVector(ackVector),
    .baseWe(baseWe), .baseWrData(baseWrData), .memReq(memReq),
    .memAddr(memAddr), .memSpace(memSpace), .memAck(memAck),
    .memData(memData), .memBusErr(memBusErr), .busy(busy), .done(done),
    .fault(fault), .vecNum(vecNum), .newPc(newPc), .initSp(initSp)
  );

  int checks = 0;
  int errors = 0;

  // memory responder state
  int            stall = 0;
  int            errWord = -1;
  int            wordCnt = 0;
  int            waitCnt = 0;
  int            unstable = 0;
  logic [AW-1:1] holdAddr;
  logic          holdSpace;
  logic [AW-1:1] recAddr [8];
  logic          recSpace [8];
  logic [AW-1:1] baseModel = '0;

  function automatic logic [15:0] fdat(input logic [AW-1:1] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] expVec(input logic [3:0] c, input logic [3:0] tn,
                                        input logic [2:0] lv, input logic [1:0] ak,
                                        input logic [7:0] av);
    case (c)
      4'd0: return 8'd0;   4'd1: return 8'd2;   4'd2: return 8'd3;
      4'd3: return 8'd4;   4'd4: return 8'd5;   4'd5: return 8'd6;
      4'd6: return 8'd7;   4'd7: return 8'd8;   4'd8: return 8'd9;
      4'd9: return 8'd10;  4'd10: return 8'd11; 4'd11: return 8'd15;
      4'd12: return 8'd32 + 8'(tn);
      4'd13: return (ak == 2'd0) ? av : (ak == 2'd1) ? 8'd24 + 8'(lv) : 8'd24;
      default: return 8'd4;
    endcase
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  initial begin
    memAck = 1'b0; memData = '0; memBusErr = 1'b0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0; memBusErr = 1'b0; wordCnt++; waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt == 0) begin
          holdAddr = memAddr; holdSpace = memSpace;
        end else if (memAddr !== holdAddr || memSpace !== holdSpace) begin
          unstable++;
        end
        if (waitCnt >= stall) begin
          memAck    = 1'b1;
          memData   = fdat(memAddr);
          memBusErr = (wordCnt == errWord);
          if (wordCnt < 8) begin
            recAddr[wordCnt]  = memAddr;
            recSpace[wordCnt] = memSpace;
          end
        end else begin
          waitCnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    baseModel = '0;
  endtask

  task automatic setBase(input logic [AW-1:1] b);
    @(negedge clk);
    baseWe = 1'b1; baseWrData = b;
    @(negedge clk);
    baseWe = 1'b0;
    baseModel = b;
  endtask

  task automatic pulseStart(input logic [3:0] c, input logic [3:0] tn, input logic [2:0] lv,
                            input logic [1:0] ak, input logic [7:0] av);
    @(negedge clk);
    cause = c; trapNum = tn; irqLevel = lv; ackKind = ak; ackVector = av; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd(output bit sawDone);
    int cyc = 0;
    sawDone = 1'b0;
    while (!done && !fault && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    sawDone = done;
  endtask

  // one full request, checked against the requirement named in rq
  task automatic runReq(input string rq, input logic [3:0] c, input logic [3:0] tn,
                        input logic [2:0] lv, input logic [1:0] ak, input logic [7:0] av,
                        input int stl);
    bit            sawDone;
    logic [7:0]    ev;
    bit            isRst;
    int            nw;
    logic [AW-1:1] wb;
    stall = stl; errWord = -1; wordCnt = 0; unstable = 0;
    pulseStart(c, tn, lv, ak, av);
    waitEnd(sawDone);
    ev    = expVec(c, tn, lv, ak, av);
    isRst = (c == 4'd0);
    nw    = isRst ? 4 : 2;
    wb    = isRst ? '0 : baseModel + {{(AW-10){1'b0}}, ev, 1'b0};
    chk(rq, "done seen", 64'(sawDone), 64'd1);
    chk(rq, "vecNum", 64'(vecNum), 64'(ev));
    chk(rq, "word count", 64'(wordCnt), 64'(nw));
    for (int i = 0; i < nw; i++) begin
      chk(rq, "word addr", 64'(recAddr[i]), 64'(wb + (AW-1)'(i)));
      chk(rq, "space", 64'(recSpace[i]), 64'(isRst));
    end
    if (isRst) begin
      chk(rq, "initSp", 64'(initSp), 64'({fdat(wb), fdat(wb + 1'b1)}));
      chk(rq, "newPc", 64'(newPc), 64'({fdat(wb + 2'd2), fdat(wb + 2'd3)}));
    end else begin
      chk(rq, "newPc", 64'(newPc), 64'({fdat(wb), fdat(wb + 1'b1)}));
    end
    chk("R8", "stall stability", 64'(unstable), 64'd0);
    @(negedge clk);
    chk("R9", "done width", 64'(done), 64'd0);
    chk("R9", "busy after done", 64'(busy), 64'd0);
  endtask

  task automatic testBusyIgnore();
    bit sawDone;
    stall = 4; errWord = -1; wordCnt = 0; unstable = 0;
    pulseStart(4'd3, 4'd0, 3'd0, 2'd0, 8'd0);
    @(negedge clk);
    cause = 4'd12; trapNum = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitEnd(sawDone);
    chk("R10", "done seen", 64'(sawDone), 64'd1);
    chk("R10", "vecNum kept", 64'(vecNum), 64'd4);
    chk("R10", "word count", 64'(wordCnt), 64'd2);
    @(negedge clk);
    chk("R10", "idle after", 64'(busy), 64'd0);
  endtask

  task automatic testFault();
    bit sawDone;
    int reqSeen = 0;
    stall = 1; errWord = 1; wordCnt = 0;
    pulseStart(4'd5, 4'd0, 3'd0, 2'd0, 8'd0);
    waitEnd(sawDone);
    chk("R11", "fault raised", 64'(fault), 64'd1);
    chk("R11", "no done", 64'(sawDone), 64'd0);
    pulseStart(4'd12, 4'd7, 3'd0, 2'd0, 8'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (memReq || done) reqSeen++;
    end
    chk("R11", "no reads or done", 64'(reqSeen), 64'd0);
    chk("R11", "words accepted", 64'(wordCnt), 64'd2);
    chk("R11", "fault held", 64'(fault), 64'd1);
    chk("R11", "busy held", 64'(busy), 64'd1);
    chk("R11", "vecNum kept", 64'(vecNum), 64'd6);
    errWord = -1;
    applyReset();
    chk("R11", "fault cleared", 64'(fault), 64'd0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; cause = '0; trapNum = '0; irqLevel = '0;
    ackKind = '0; ackVector = '0; baseWe = 1'b0; baseWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "reset busy", 64'(busy), 64'd0);
    chk("R9", "reset done", 64'(done), 64'd0);
    chk("R9", "reset fault", 64'(fault), 64'd0);
    chk("R9", "reset memReq", 64'(memReq), 64'd0);

    runReq("R1", 4'd3, 4'd0, 3'd0, 2'd0, 8'd0, 0);        // illegal -> 4
    runReq("R1", 4'd11, 4'd0, 3'd0, 2'd0, 8'd0, 2);       // uninit -> 15
    runReq("R1", 4'd14, 4'd0, 3'd0, 2'd0, 8'd0, 0);       // unused code -> 4
    runReq("R1", 4'd10, 4'd0, 3'd0, 2'd0, 8'd0, 1);       // line-F -> 11
    runReq("R2", 4'd12, 4'd15, 3'd0, 2'd0, 8'd0, 0);      // trap 15 -> 47
    runReq("R2", 4'd12, 4'd0, 3'd0, 2'd0, 8'd0, 3);       // trap 0 -> 32
    runReq("R3", 4'd13, 4'd0, 3'd2, 2'd0, 8'hC7, 0);      // peripheral byte
    runReq("R3", 4'd13, 4'd0, 3'd7, 2'd1, 8'hFF, 0);      // autovector 7 -> 31
    runReq("R3", 4'd13, 4'd0, 3'd5, 2'd2, 8'h80, 1);      // ack error -> 24
    runReq("R3", 4'd13, 4'd0, 3'd1, 2'd3, 8'h80, 0);      // ack error -> 24
    runReq("R7", 4'd0, 4'd0, 3'd0, 2'd0, 8'd0, 3);        // reset, stalled
    runReq("R6", 4'd8, 4'd0, 3'd0, 2'd0, 8'd0, 5);        // trace, long stall

    setBase(23'h000800);
    runReq("R5", 4'd12, 4'd3, 3'd0, 2'd0, 8'd0, 0);       // base + trap 3
    runReq("R5", 4'd0, 4'd0, 3'd0, 2'd0, 8'd0, 0);        // reset ignores base
    setBase(23'h7FFFF8);
    runReq("R4", 4'd3, 4'd0, 3'd0, 2'd0, 8'd0, 0);        // wraps to word 0

    testBusyIgnore();
    testFault();
    runReq("R5", 4'd12, 4'd1, 3'd0, 2'd0, 8'd0, 0);       // base back to zero

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule